// File: doc/BRIEF.md
# Interlaced 625-Line Vertical Interval Sequencer

This block produces the vertical timing of a 625-line, 50-field interlaced raster at half-line granularity. An external horizontal counter supplies a tick at every half-line boundary; the block counts these ticks through a frame of 1250 half-line periods. For each half-line period it reports what kind of sync that period carries: broad field-sync pulses, equalizing pulses, ordinary line sync, or active picture.

It also reports which of the two fields is current, a vertical-blanking flag, and the current line number (1 to 625). The two fields share one region layout, offset by exactly 625 half-lines. As a result, the second field's sync and picture begin half a line later within their lines than the first field's. A downstream waveform stage or capture window uses these outputs to place sync pulses and to gate picture data.

Top module: `vsg625_top`

## Requirements
- R1: A synchronous active-high `rst` returns the block to half-line 0. In that state `pulse_code` reads 01 (broad), `field_id` is 0, `vblank` is 1 and `line_num` is 1.
- R2: The half-line position advances by one on a rising `clk` edge only when `pix_ce` and `half_tick` are both high. Otherwise every output holds its value.
- R3: A frame has 1250 half-line positions (0 to 1249). Advancing from position 1249 returns to position 0.
- R4: `pulse_code` uses this encoding: 2'b00 means normal line sync, 2'b01 means broad field-sync, 2'b10 means equalizing, and 2'b11 means active image.
- R5: In the first field (positions 0 to 624), the pulse types are: 01 at positions 0-4, 10 at 5-9, 00 at 10-44, 11 at 45-619 and 10 at 620-624.
- R6: The second field (positions 625 to 1249) repeats the layout of R5 shifted by 625 half-lines. That gives 01 at 625-629, 10 at 630-634, 00 at 635-669, 11 at 670-1244 and 10 at 1245-1249.
- R7: `field_id` is 0 at positions 0 to 624 and 1 at positions 625 to 1249. It therefore changes exactly when the second field's broad sync begins and again on the wrap to position 0.
- R8: `vblank` is high exactly when `pulse_code` is not 11. Over one frame this gives 50 blanked and 575 image half-lines per field.
- R9: `line_num` equals floor(position/2)+1. It changes only on entry to an even position, so line 313 spans positions 624 and 625.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel clock enable |
| half_tick | input | 1 | Half-line boundary strobe from the horizontal counter |
| pulse_code | output | 2 | Pulse type of the current half-line (R4 encoding) |
| field_id | output | 1 | 0 in the first field, 1 in the second |
| vblank | output | 1 | High outside the active image region |
| line_num | output | 10 | Current line, 1 to 625 |

## Verification
The bench walks more than two complete frames, one half-line at a time, and compares every output against arithmetic expectations. This exposes off-by-one region edges: a boundary placed one half-line early or late shows up at a position such as 9, 45 or 620. It also exposes a wrong second-field offset, which would start the second field's sync or picture on a whole-line rather than a half-line boundary. It also exercises the wrap from 1249 to 0; a counter that wraps at 1250 would produce an extra half-line of equalizing pulses and a line 626. Hold cycles with only one of the two advance inputs high catch a design that advances on either input alone. A reset in mid-frame checks that the state returns to broad sync in the first field, even while the advance inputs are held high.

// File: rtl/vsg625_pkg.sv
package vsg625_pkg;

   typedef enum logic [1:0] {
      PT_NORMAL = 2'b00,
      PT_BROAD  = 2'b01,
      PT_EQUAL  = 2'b10,
      PT_IMAGE  = 2'b11
   } pulse_t;

endpackage

// File: rtl/vsg_hl_counter.sv
module vsg_hl_counter #(
   parameter int HL_FRAME = 1250,
   parameter int HL_FIELD = 625,
   parameter int HW       = $clog2(HL_FRAME)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [HW-1:0] hl,
   output logic          fld,
   output logic [HW-1:0] loc
);
   localparam logic [HW-1:0] LAST  = HW'(HL_FRAME - 1);
   localparam logic [HW-1:0] SPLIT = HW'(HL_FIELD);

   if (HL_FIELD * 2 != HL_FRAME) begin : g_bad_split
      $error("frame must hold two equal fields");
   end

   always_ff @(posedge clk) begin
      if (rst)
         hl <= '0;
      else if (adv)
         hl <= (hl == LAST) ? '0 : hl + HW'(1);
   end

   assign fld = (hl >= SPLIT);
   assign loc = fld ? (hl - SPLIT) : hl;

   // R3: position 1249 wraps to 0
   a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
      (adv && hl == LAST) |=> (hl == '0));

   // R3: position never leaves the frame
   a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
      (hl <= LAST));

   // R2: no advance without both enables
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(hl));

   // R7: field rises only on entry to the second field
   a_r7_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(fld) |-> (hl == SPLIT));

   // R7: field falls only on wrap
   a_r7_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(fld) |-> (hl == '0));

endmodule

// File: rtl/vsg_region_decode.sv
module vsg_region_decode
   import vsg625_pkg::*;
#(
   parameter int HW        = 11,
   parameter int BROAD_HL  = 5,
   parameter int EQU_HL    = 5,
   parameter int IMG_START = 45,
   parameter int IMG_HL    = 575
) (
   input  logic [HW-1:0] loc,
   output pulse_t        code
);
   localparam logic [HW-1:0] END_BROAD = HW'(BROAD_HL);
   localparam logic [HW-1:0] END_PRE   = HW'(BROAD_HL + EQU_HL);
   localparam logic [HW-1:0] END_BLANK = HW'(IMG_START);
   localparam logic [HW-1:0] END_IMG   = HW'(IMG_START + IMG_HL);

   if (BROAD_HL + EQU_HL > IMG_START) begin : g_bad_layout
      $error("image region overlaps pre-sync pulses");
   end

   always_comb begin
      if (loc < END_BROAD)
         code = PT_BROAD;
      else if (loc < END_PRE)
         code = PT_EQUAL;
      else if (loc < END_BLANK)
         code = PT_NORMAL;
      else if (loc < END_IMG)
         code = PT_IMAGE;
      else
         code = PT_EQUAL;
   end

endmodule

// File: rtl/vsg625_top.sv
module vsg625_top
   import vsg625_pkg::*;
#(
   parameter int LINES     = 625,
   parameter int BROAD_HL  = 5,
   parameter int EQU_HL    = 5,
   parameter int IMG_START = 45,
   parameter int IMG_HL    = 575,
   parameter bit OUT_REG   = 1'b0,
   parameter int LW        = $clog2(LINES + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pix_ce,
   input  logic          half_tick,
   output logic [1:0]    pulse_code,
   output logic          field_id,
   output logic          vblank,
   output logic [LW-1:0] line_num
);
   localparam int HL_FRAME = 2 * LINES;
   localparam int HL_FIELD = LINES;
   localparam int HW       = $clog2(HL_FRAME);
   localparam logic [HW-1:0] LAST  = HW'(HL_FRAME - 1);
   localparam logic [HW-1:0] SPLIT = HW'(HL_FIELD);

   if (LINES % 2 == 0) begin : g_bad_lines
      $error("interlace needs an odd line count");
   end
   if (IMG_START + IMG_HL + EQU_HL != HL_FIELD) begin : g_bad_field
      $error("field regions must fill the field exactly");
   end

   logic          adv;
   logic [HW-1:0] hl;
   logic          fld;
   logic [HW-1:0] loc;
   pulse_t        code_c;
   logic          vblank_c;
   logic [LW-1:0] line_c;

   assign adv = pix_ce & half_tick;

   vsg_hl_counter #(
      .HL_FRAME(HL_FRAME),
      .HL_FIELD(HL_FIELD),
      .HW      (HW)
   ) u_cnt (
      .clk(clk),
      .rst(rst),
      .adv(adv),
      .hl (hl),
      .fld(fld),
      .loc(loc)
   );

   vsg_region_decode #(
      .HW       (HW),
      .BROAD_HL (BROAD_HL),
      .EQU_HL   (EQU_HL),
      .IMG_START(IMG_START),
      .IMG_HL   (IMG_HL)
   ) u_dec (
      .loc (loc),
      .code(code_c)
   );

   assign vblank_c = (code_c != PT_IMAGE);
   assign line_c   = LW'(hl >> 1) + LW'(1);

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            pulse_code <= PT_BROAD;
            field_id   <= 1'b0;
            vblank     <= 1'b1;
            line_num   <= LW'(1);
         end else begin
            pulse_code <= code_c;
            field_id   <= fld;
            vblank     <= vblank_c;
            line_num   <= line_c;
         end
      end
   end else begin : g_out_comb
      assign pulse_code = code_c;
      assign field_id   = fld;
      assign vblank     = vblank_c;
      assign line_num   = line_c;
   end

   // R5 / R6: both fields open with broad sync
   a_r6_field_start_broad: assert property (@(posedge clk) disable iff (rst)
      (hl == '0 || hl == SPLIT) |-> (code_c == PT_BROAD));

   // R9: line advances on entry to an even position
   a_r9_line_step: assert property (@(posedge clk) disable iff (rst)
      (adv && hl[0] && hl != LAST) |=> (line_c == $past(line_c) + LW'(1)));

   // R9: line holds across the mid-line boundary
   a_r9_line_hold: assert property (@(posedge clk) disable iff (rst)
      (adv && !hl[0]) |=> $stable(line_c));

   // R1: reset lands on first-field broad sync
   a_r1_reset: assert property (@(posedge clk)
      rst |=> (hl == '0));

endmodule

// File: tb/vsg625_top_tb_top.sv
module vsg625_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NHL = 1250;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pix_ce = 1'b0;
   logic       half_tick = 1'b0;
   logic [1:0] pulse_code;
   logic       field_id;
   logic       vblank;
   logic [9:0] line_num;

   int total = 0;
   int bad = 0;
   int m_hl = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vsg625_top dut_i (
      .clk       (clk),
      .rst       (rst),
      .pix_ce    (pix_ce),
      .half_tick (half_tick),
      .pulse_code(pulse_code),
      .field_id  (field_id),
      .vblank    (vblank),
      .line_num  (line_num)
   );

   // R4 encoding: 00 normal, 01 broad, 10 equalizing, 11 image
   function automatic logic [1:0] exp_code(input int h);
      int k;
      k = (h >= 625) ? h - 625 : h;
      if (k < 5) return 2'b01;
      if (k < 10) return 2'b10;
      if (k < 45) return 2'b00;
      if (k < 620) return 2'b11;
      return 2'b10;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at hl=%0d: actual=%0d expected=%0d", req, m_hl, act, exp);
      end
   endtask

   task automatic check_all();
      chk((m_hl < 625) ? "R5 code" : "R6 code", int'(pulse_code), int'(exp_code(m_hl)));
      chk("R7 field", int'(field_id), (m_hl >= 625) ? 1 : 0);
      chk("R8 vblank", int'(vblank), (exp_code(m_hl) != 2'b11) ? 1 : 0);
      chk("R9 line", int'(line_num), m_hl / 2 + 1);
   endtask

   // called at a negedge; returns at the following negedge
   task automatic step(input logic c, input logic t);
      pix_ce = c;
      half_tick = t;
      @(posedge clk);
      if (rst) m_hl = 0;
      else if (c && t) m_hl = (m_hl + 1) % NHL;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      int vb_cnt;
      int img_cnt;
      int wraps;
      int fld_edges;
      logic prev_fld;
      vb_cnt = 0;
      img_cnt = 0;
      wraps = 0;
      fld_edges = 0;
      @(negedge clk);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      rst = 1'b0;
      // R1 reset state
      chk("R1 code", int'(pulse_code), 1);
      chk("R1 field", int'(field_id), 0);
      chk("R1 vblank", int'(vblank), 1);
      chk("R1 line", int'(line_num), 1);
      // R2 hold with partial enables
      step(1'b1, 1'b0); chk("R2 hold ce only", int'(line_num) * 4 + int'(pulse_code), 1 * 4 + 1);
      step(1'b0, 1'b1); chk("R2 hold tick only", int'(line_num) * 4 + int'(pulse_code), 1 * 4 + 1);
      step(1'b0, 1'b0); chk("R2 hold idle", m_hl, 0);
      check_all();
      // sweep over two frames plus a margin (R3, R5, R6, R7, R8, R9)
      prev_fld = field_id;
      for (int i = 0; i < 2 * NHL + 12; i++) begin
         step(1'b1, 1'b1);
         if (m_hl == 0) wraps++;
         check_all();
         if (field_id != prev_fld) fld_edges++;
         prev_fld = field_id;
         if (wraps == 1) begin
            if (vblank) vb_cnt++;
            if (pulse_code == 2'b11) img_cnt++;
         end
         if (i % 97 == 3) begin
            step(1'b1, 1'b0);
            check_all();
            step(1'b0, 1'b1);
            check_all();
         end
      end
      chk("R3 wraps", wraps, 2);
      chk("R7 field edges", fld_edges, 4);
      chk("R8 blank count", vb_cnt, 100);
      chk("R8 image count", img_cnt, 1150);
      // R1 reset in mid-frame with enables held
      rst = 1'b1;
      step(1'b1, 1'b1);
      rst = 1'b0;
      chk("R1 midframe code", int'(pulse_code), 1);
      chk("R1 midframe line", int'(line_num), 1);
      chk("R1 midframe field", int'(field_id), 0);
      step(1'b1, 1'b1);
      check_all();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule